// File: doc/BRIEF.md
# Multiple Shallow Stack Execution Unit

This block is an integer datapath built from several independent operand stacks, each only a few entries deep on chip. Every stack has its own command port carrying push, pop, unary and binary operations. Operands are implicit: arithmetic and logic work on the top entries and leave their result on top. When a stack's on-chip entries run out, the deepest entry spills to a backing memory. When they drain, an entry comes back from that memory. All of this traffic goes through one shared request/acknowledge memory port.

The stacks run in parallel, so each may accept a command in the same clock cycle. Values pass between stacks only by a transfer, which pops the source top and pushes it onto the destination top. Each command port follows valid/ready rules. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The source keeps the command stable until it is taken. `cmd_ready` may depend on `cmd_valid` within the same cycle, because transfer arbitration looks at the valid commands. On the memory side, `mem_req` together with its address, write flag and write data stays stable until the cycle in which `mem_ack` is high. The acknowledge lasts one cycle, and read data is presented with it.

Each stack owns a spill region of 2^SLOT_W words at address {stack index, slot}, with slots filled upward from 0. The depth of a stack is therefore bounded by the on-chip entries plus 2^SLOT_W spilled words; pushes beyond that are unsupported.

Top module: `mss_unit`

## Requirements
- R1: Op code 1 (push) puts `cmd_data` on the stack top and op code 2 (pop) discards the top. Op code 0 and codes 11 to 15 do nothing. `top_empty` is high exactly when the stack holds no entry, and `top_data` shows the current top one cycle after the accepting edge when no memory access is needed.
- R2: The binary op codes are 3 ADD, 4 SUB, 5 AND, 6 OR and 7 XOR. Each consumes the top and the entry beneath it and leaves one result on top. For SUB the result is (entry beneath) minus (top), modulo 2^WIDTH.
- R3: The unary op codes are 8 NOT (bitwise invert) and 9 NEG (two's complement negate). Each replaces the top in place.
- R4: A push onto a stack whose 4 on-chip entries are all occupied first writes the deepest on-chip entry to address {stack, slot}, where slot is the current spill count. Only then does the new value become the top.
- R5: A pop that would leave no on-chip entry while spilled entries exist reads the most recently spilled slot back as the new top. A binary op with only one on-chip entry reads its second operand from that slot.
- R6: Op code 10 (transfer), with a destination index in `cmd_dst`, pops the source top and pushes it onto the destination. At most one transfer is taken per cycle, and the lowest-numbered source wins. The destination's own port is not ready in the cycle it receives a transferred value.
- R7: A transfer whose destination equals its source changes nothing.
- R8: A pop, transfer or unary op on an empty stack, or a binary op on a stack holding fewer than two entries (on chip plus spilled), sets that stack's `err_uflow` bit. The bit stays set until reset, and the stack contents are left unchanged.
- R9: Stacks are independent: with no memory access pending, all stacks accept a command in the same cycle.
- R10: When several stacks need memory at once, the lowest-numbered one is served first. A request and its address stay stable until acknowledged.
- R11: `stall` of a stack is high while it waits for or uses the memory port, and during that time its `cmd_ready` is low.
- R12: After reset every stack is empty, no `err_uflow` bit is set, every `cmd_ready` is high and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NSTK | Command valid, one bit per stack |
| cmd_ready | output | NSTK | Command ready, one bit per stack |
| cmd_op | input | NSTK*4 | Op code per stack |
| cmd_data | input | NSTK*WIDTH | Push value per stack |
| cmd_dst | input | NSTK*log2(NSTK) | Transfer destination per stack |
| top_data | output | NSTK*WIDTH | Current top value per stack |
| top_empty | output | NSTK | Stack holds no entry |
| stall | output | NSTK | Stack waiting on memory |
| err_uflow | output | NSTK | Sticky underflow flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = spill write, 0 = refill read |
| mem_addr | output | log2(NSTK)+SLOT_W | Word address {stack, slot} |
| mem_wdata | output | WIDTH | Spilled value |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | WIDTH | Refill value, valid with ack |

## Verification
Two collisions are provoked on purpose. In the first, two stacks that both hold four on-chip entries receive a push on the same edge. Both then need to spill, so the memory model logs the order of acknowledged addresses, and the lower stack's address must come first; the higher stack must show stall with ready low while it waits. In the second, two stacks issue transfers to a third in the same cycle while that third stack presents its own push. Ready is sampled before the edge: only the lowest source may be ready, and the destination must not be. The resulting tops then show which value landed where.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_NEG  = 4'd9,
    OP_XFER = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    LS_IDLE,
    LS_SPILL,
    LS_PREFILL,
    LS_REFILL
  } lane_st_e;
endpackage

// File: rtl/mss_lane.sv
module mss_lane
  import mss_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DEPTH   = 4,
  parameter int SLOT_W  = 4,
  parameter int SW      = 2,
  parameter int LANE_ID = 0,
  localparam int AW     = SW + SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  op_e              cmd_op,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic             inj_go,
  input  logic [WIDTH-1:0] inj_data,
  output logic             idle,
  output logic             nonempty,
  output logic [WIDTH-1:0] top,
  output logic             err,
  output logic             mreq,
  output logic             mwe,
  output logic [AW-1:0]    maddr,
  output logic [WIDTH-1:0] mwdata,
  input  logic             mack,
  input  logic [WIDTH-1:0] mrdata
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = ((CW > SLOT_W + 1) ? CW : SLOT_W + 1) + 1;

  lane_st_e          st, st_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [SLOT_W:0]   spl, spl_n;
  logic [WIDTH-1:0]  ent   [DEPTH];
  logic [WIDTH-1:0]  ent_n [DEPTH];
  logic [WIDTH-1:0]  pend_data, pend_data_n;
  op_e               pend_op, pend_op_n;
  logic              err_n;

  op_e               op_in;
  logic [WIDTH-1:0]  din;
  logic              go;
  logic [TW-1:0]     total;
  logic [SLOT_W:0]   spl_m1;
  logic              is_bin, is_un;

  function automatic logic [WIDTH-1:0] calc(op_e op, logic [WIDTH-1:0] nx, logic [WIDTH-1:0] tp);
    case (op)
      OP_ADD:  return nx + tp;
      OP_SUB:  return nx - tp;
      OP_AND:  return nx & tp;
      OP_OR:   return nx | tp;
      OP_XOR:  return nx ^ tp;
      OP_NOT:  return ~tp;
      OP_NEG:  return '0 - tp;
      default: return tp;
    endcase
  endfunction

  assign go     = cmd_go | inj_go;
  assign op_in  = inj_go ? OP_PUSH : cmd_op;
  assign din    = inj_go ? inj_data : cmd_data;
  assign total  = TW'(cnt) + TW'(spl);
  assign spl_m1 = spl - 1'b1;
  assign is_bin = (op_in == OP_ADD) || (op_in == OP_SUB) || (op_in == OP_AND) ||
                  (op_in == OP_OR)  || (op_in == OP_XOR);
  assign is_un  = (op_in == OP_NOT) || (op_in == OP_NEG);

  always_comb begin
    st_n        = st;
    cnt_n       = cnt;
    spl_n       = spl;
    pend_data_n = pend_data;
    pend_op_n   = pend_op;
    err_n       = err;
    for (int k = 0; k < DEPTH; k++) ent_n[k] = ent[k];
    unique case (st)
      LS_IDLE: begin
        if (go) begin
          if (op_in == OP_PUSH) begin
            if (cnt == CW'(DEPTH)) begin
              st_n        = LS_SPILL;
              pend_data_n = din;
            end else begin
              for (int k = 1; k < DEPTH; k++) ent_n[k] = ent[k-1];
              ent_n[0] = din;
              cnt_n    = cnt + CW'(1);
            end
          end else if (op_in == OP_POP) begin
            if (total == TW'(0)) begin
              err_n = 1'b1;
            end else if (cnt == CW'(1) && spl != '0) begin
              st_n = LS_REFILL;
            end else begin
              for (int k = 0; k < DEPTH - 1; k++) ent_n[k] = ent[k+1];
              cnt_n = cnt - CW'(1);
            end
          end else if (is_bin) begin
            if (total < TW'(2)) begin
              err_n = 1'b1;
            end else if (cnt == CW'(1)) begin
              st_n      = LS_PREFILL;
              pend_op_n = op_in;
            end else begin
              ent_n[0] = calc(op_in, ent[1], ent[0]);
              for (int k = 1; k < DEPTH - 1; k++) ent_n[k] = ent[k+1];
              cnt_n = cnt - CW'(1);
            end
          end else if (is_un) begin
            if (total == TW'(0)) err_n = 1'b1;
            else ent_n[0] = calc(op_in, '0, ent[0]);
          end
        end
      end
      LS_SPILL: begin
        if (mack) begin
          for (int k = 1; k < DEPTH; k++) ent_n[k] = ent[k-1];
          ent_n[0] = pend_data;
          spl_n    = spl + 1'b1;
          st_n     = LS_IDLE;
        end
      end
      LS_PREFILL: begin
        if (mack) begin
          ent_n[0] = calc(pend_op, mrdata, ent[0]);
          spl_n    = spl_m1;
          st_n     = LS_IDLE;
        end
      end
      LS_REFILL: begin
        if (mack) begin
          ent_n[0] = mrdata;
          spl_n    = spl_m1;
          st_n     = LS_IDLE;
        end
      end
      default: st_n = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= LS_IDLE;
      cnt       <= '0;
      spl       <= '0;
      err       <= 1'b0;
      pend_op   <= OP_NOP;
      pend_data <= '0;
      for (int k = 0; k < DEPTH; k++) ent[k] <= '0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      spl       <= spl_n;
      err       <= err_n;
      pend_op   <= pend_op_n;
      pend_data <= pend_data_n;
      for (int k = 0; k < DEPTH; k++) ent[k] <= ent_n[k];
    end
  end

  assign idle     = (st == LS_IDLE);
  assign nonempty = (cnt != '0);
  assign top      = ent[0];
  assign mreq     = (st != LS_IDLE);
  assign mwe      = (st == LS_SPILL);
  assign mwdata   = ent[DEPTH-1];
  assign maddr    = {SW'(LANE_ID), (st == LS_SPILL) ? spl[SLOT_W-1:0] : spl_m1[SLOT_W-1:0]};

  AST_SPILL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_SPILL) |-> (cnt == CW'(DEPTH))); // R4
  AST_TOP_ON_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (spl != '0) |-> (cnt != '0)); // R5
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_UFLOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($stable(cnt) && $stable(spl) && $stable(ent[0]))); // R8
  AST_LANE_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && !mack) |=> (mreq && $stable(maddr))); // R10
  AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (!cmd_go && !inj_go)); // R11
endmodule

// File: rtl/mss_arb.sv
module mss_arb #(
  parameter int N     = 4,
  parameter int AW    = 6,
  parameter int WIDTH = 16,
  localparam int SW   = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req,
  input  logic [N-1:0]       we,
  input  logic [N*AW-1:0]    addr,
  input  logic [N*WIDTH-1:0] wdata,
  output logic [N-1:0]       ack,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [WIDTH-1:0]   mem_wdata,
  input  logic               mem_ack
);
  logic          locked;
  logic [SW-1:0] own, pick, sel;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) if (req[i]) pick = SW'(i);
  end

  assign sel       = locked ? own : pick;
  assign mem_req   = req[sel];
  assign mem_we    = we[sel];
  assign mem_addr  = addr[sel*AW +: AW];
  assign mem_wdata = wdata[sel*WIDTH +: WIDTH];

  always_comb begin
    for (int i = 0; i < N; i++) ack[i] = mem_ack && mem_req && (sel == SW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      own    <= '0;
    end else if (mem_req && !mem_ack) begin
      locked <= 1'b1;
      own    <= sel;
    end else begin
      locked <= 1'b0;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)); // R10
  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_OWNER_STILL_ASKS: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> req[own]); // R10
endmodule

// File: rtl/mss_unit.sv
module mss_unit
  import mss_pkg::*;
#(
  parameter int NSTK   = 4,
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 4,
  parameter int SLOT_W = 4,
  localparam int SW    = $clog2(NSTK),
  localparam int AW    = SW + SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSTK-1:0]       cmd_valid,
  output logic [NSTK-1:0]       cmd_ready,
  input  logic [NSTK*4-1:0]     cmd_op,
  input  logic [NSTK*WIDTH-1:0] cmd_data,
  input  logic [NSTK*SW-1:0]    cmd_dst,
  output logic [NSTK*WIDTH-1:0] top_data,
  output logic [NSTK-1:0]       top_empty,
  output logic [NSTK-1:0]       stall,
  output logic [NSTK-1:0]       err_uflow,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [WIDTH-1:0]      mem_wdata,
  input  logic                  mem_ack,
  input  logic [WIDTH-1:0]      mem_rdata
);
  op_e              op_s   [NSTK];
  op_e              eff_op [NSTK];
  logic [SW-1:0]    dst_s  [NSTK];
  logic [WIDTH-1:0] top_q  [NSTK];
  logic [NSTK-1:0]  idle, nonempty, xreq, xreal, inj_go, go;
  logic             xg_valid;
  logic [SW-1:0]    xg_src, xg_dst;
  logic [WIDTH-1:0] inj_data;

  logic [NSTK-1:0]       lreq, lwe, lack;
  logic [NSTK*AW-1:0]    laddr;
  logic [NSTK*WIDTH-1:0] lwdata;

  always_comb begin
    for (int s = 0; s < NSTK; s++) begin
      op_s[s]  = op_e'(cmd_op[s*4 +: 4]);
      dst_s[s] = cmd_dst[s*SW +: SW];
      xreal[s] = (op_s[s] == OP_XFER) && (dst_s[s] != SW'(s)) && nonempty[s];
      xreq[s]  = cmd_valid[s] && xreal[s] && idle[s] && idle[dst_s[s]];
      if (op_s[s] == OP_XFER) eff_op[s] = (dst_s[s] == SW'(s)) ? OP_NOP : OP_POP;
      else eff_op[s] = op_s[s];
    end
  end

  always_comb begin
    xg_valid = 1'b0;
    xg_src   = '0;
    for (int s = 0; s < NSTK; s++) begin
      if (xreq[s] && !xg_valid) begin
        xg_valid = 1'b1;
        xg_src   = SW'(s);
      end
    end
    xg_dst   = dst_s[xg_src];
    inj_data = top_q[xg_src];
    for (int d = 0; d < NSTK; d++) inj_go[d] = xg_valid && (xg_dst == SW'(d));
    for (int s = 0; s < NSTK; s++) begin
      cmd_ready[s] = idle[s] && !inj_go[s] && (!xreal[s] || (xg_valid && xg_src == SW'(s)));
      go[s]        = cmd_valid[s] && cmd_ready[s];
    end
  end

  for (genvar g = 0; g < NSTK; g++) begin : g_lane
    mss_lane #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .SLOT_W(SLOT_W), .SW(SW), .LANE_ID(g)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_go   (go[g]),
      .cmd_op   (eff_op[g]),
      .cmd_data (cmd_data[g*WIDTH +: WIDTH]),
      .inj_go   (inj_go[g]),
      .inj_data (inj_data),
      .idle     (idle[g]),
      .nonempty (nonempty[g]),
      .top      (top_q[g]),
      .err      (err_uflow[g]),
      .mreq     (lreq[g]),
      .mwe      (lwe[g]),
      .maddr    (laddr[g*AW +: AW]),
      .mwdata   (lwdata[g*WIDTH +: WIDTH]),
      .mack     (lack[g]),
      .mrdata   (mem_rdata)
    );
    assign top_data[g*WIDTH +: WIDTH] = top_q[g];
    assign top_empty[g] = !nonempty[g];
    assign stall[g]     = !idle[g];

    AST_NO_READY_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      stall[g] |-> !cmd_ready[g]); // R11
  end

  mss_arb #(.N(NSTK), .AW(AW), .WIDTH(WIDTH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (lreq),
    .we        (lwe),
    .addr      (laddr),
    .wdata     (lwdata),
    .ack       (lack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
  );

  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inj_go)); // R6
  AST_XFER_DST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_go & go) == '0); // R6
endmodule

// File: tb/mss_unit_bench.sv
module mss_unit_bench;
  localparam int N = 4, W = 16, AW = 6, LAT = 2, NV = 41;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]   cmd_valid = '0;
  logic [N-1:0]   cmd_ready;
  logic [N*4-1:0] cmd_op = '0;
  logic [N*W-1:0] cmd_data = '0;
  logic [N*2-1:0] cmd_dst = '0;
  logic [N*W-1:0] top_data;
  logic [N-1:0]   top_empty, stall, err_uflow;
  logic           mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0]  mem_addr;
  logic [W-1:0]   mem_wdata, mem_rdata = '0;

  logic [W-1:0]  mem  [64];
  logic [AW-1:0] alog [8];
  int nlog = 0, wcnt = 0, checks = 0, fails = 0;

  always #5 clk = ~clk;

  mss_unit u_mss_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_dst(cmd_dst), .top_data(top_data),
    .top_empty(top_empty), .stall(stall), .err_uflow(err_uflow), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model: acknowledge after LAT cycles, log served addresses
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req) begin
      if (wcnt == LAT) begin
        wcnt = 0;
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata = mem[mem_addr];
        mem_ack = 1'b1;
        if (nlog < 8) alog[nlog] = mem_addr;
        nlog++;
      end else wcnt++;
    end
  end

  // {lane, op, data, dst, check lane, expected top, expected empty}
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 4'd1, 16'h0011, 2'd0, 2'd0, 16'h0011, 1'b0},  // R1
    {2'd0, 4'd1, 16'h0022, 2'd0, 2'd0, 16'h0022, 1'b0},
    {2'd0, 4'd3, 16'h0000, 2'd0, 2'd0, 16'h0033, 1'b0},  // R2 ADD
    {2'd0, 4'd1, 16'h0005, 2'd0, 2'd0, 16'h0005, 1'b0},
    {2'd0, 4'd4, 16'h0000, 2'd0, 2'd0, 16'h002E, 1'b0},  // R2 SUB
    {2'd0, 4'd1, 16'h00F0, 2'd0, 2'd0, 16'h00F0, 1'b0},
    {2'd0, 4'd6, 16'h0000, 2'd0, 2'd0, 16'h00FE, 1'b0},  // R2 OR
    {2'd0, 4'd1, 16'h0F0F, 2'd0, 2'd0, 16'h0F0F, 1'b0},
    {2'd0, 4'd5, 16'h0000, 2'd0, 2'd0, 16'h000E, 1'b0},  // R2 AND
    {2'd0, 4'd1, 16'h00FF, 2'd0, 2'd0, 16'h00FF, 1'b0},
    {2'd0, 4'd7, 16'h0000, 2'd0, 2'd0, 16'h00F1, 1'b0},  // R2 XOR
    {2'd0, 4'd8, 16'h0000, 2'd0, 2'd0, 16'hFF0E, 1'b0},  // R3 NOT
    {2'd0, 4'd9, 16'h0000, 2'd0, 2'd0, 16'h00F2, 1'b0},  // R3 NEG
    {2'd0, 4'd2, 16'h0000, 2'd0, 2'd0, 16'h0000, 1'b1},  // R1 pop to empty
    {2'd1, 4'd1, 16'h0001, 2'd0, 2'd1, 16'h0001, 1'b0},
    {2'd1, 4'd1, 16'h0002, 2'd0, 2'd1, 16'h0002, 1'b0},
    {2'd1, 4'd1, 16'h0003, 2'd0, 2'd1, 16'h0003, 1'b0},
    {2'd1, 4'd1, 16'h0004, 2'd0, 2'd1, 16'h0004, 1'b0},
    {2'd1, 4'd1, 16'h0005, 2'd0, 2'd1, 16'h0005, 1'b0},  // R4 spill
    {2'd1, 4'd1, 16'h0006, 2'd0, 2'd1, 16'h0006, 1'b0},  // R4 spill
    {2'd1, 4'd2, 16'h0000, 2'd0, 2'd1, 16'h0005, 1'b0},
    {2'd1, 4'd2, 16'h0000, 2'd0, 2'd1, 16'h0004, 1'b0},
    {2'd1, 4'd2, 16'h0000, 2'd0, 2'd1, 16'h0003, 1'b0},
    {2'd1, 4'd2, 16'h0000, 2'd0, 2'd1, 16'h0002, 1'b0},  // R5 refill
    {2'd1, 4'd2, 16'h0000, 2'd0, 2'd1, 16'h0001, 1'b0},  // R5 refill
    {2'd1, 4'd2, 16'h0000, 2'd0, 2'd1, 16'h0000, 1'b1},
    {2'd2, 4'd1, 16'h000A, 2'd0, 2'd2, 16'h000A, 1'b0},
    {2'd2, 4'd1, 16'h0002, 2'd0, 2'd2, 16'h0002, 1'b0},
    {2'd2, 4'd1, 16'h0003, 2'd0, 2'd2, 16'h0003, 1'b0},
    {2'd2, 4'd1, 16'h0004, 2'd0, 2'd2, 16'h0004, 1'b0},
    {2'd2, 4'd1, 16'h0005, 2'd0, 2'd2, 16'h0005, 1'b0},  // R4
    {2'd2, 4'd2, 16'h0000, 2'd0, 2'd2, 16'h0004, 1'b0},
    {2'd2, 4'd2, 16'h0000, 2'd0, 2'd2, 16'h0003, 1'b0},
    {2'd2, 4'd2, 16'h0000, 2'd0, 2'd2, 16'h0002, 1'b0},
    {2'd2, 4'd4, 16'h0000, 2'd0, 2'd2, 16'h0008, 1'b0},  // R5 operand from memory
    {2'd2, 4'd2, 16'h0000, 2'd0, 2'd2, 16'h0000, 1'b1},
    {2'd3, 4'd1, 16'h0077, 2'd0, 2'd3, 16'h0077, 1'b0},
    {2'd3, 4'd10, 16'h0000, 2'd0, 2'd0, 16'h0077, 1'b0}, // R6 transfer 3 to 0
    {2'd3, 4'd0, 16'h0000, 2'd0, 2'd3, 16'h0000, 1'b1},  // R6 source emptied
    {2'd0, 4'd10, 16'h0000, 2'd0, 2'd0, 16'h0077, 1'b0}, // R7 self transfer
    {2'd0, 4'd2, 16'h0000, 2'd0, 2'd0, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input int l, input logic [3:0] op, input logic [W-1:0] d, input int dst);
    cmd_valid[l] = 1'b1;
    cmd_op[l*4 +: 4] = op;
    cmd_data[l*W +: W] = d;
    cmd_dst[l*2 +: 2] = 2'(dst);
  endtask

  task automatic quiet();
    while (|stall) @(negedge clk);
  endtask

  task automatic run1(input int l, input logic [3:0] op, input logic [W-1:0] d, input int dst);
    @(negedge clk);
    drive(l, op, d, dst);
    #1;
    while (!cmd_ready[l]) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid[l] = 1'b0;
    quiet();
  endtask

  function automatic logic [W-1:0] topof(input int l);
    return top_data[l*W +: W];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12 empty", W'(top_empty), W'(4'hF));
    chk("R12 err", W'(err_uflow), '0);
    chk("R12 ready", W'(cmd_ready), W'(4'hF));
    chk("R12 mem_req", W'(mem_req), '0);

    for (int v = 0; v < NV; v++) begin
      logic [42:0] e;
      e = VEC[v];
      run1(int'(e[42:41]), e[40:37], e[36:21], int'(e[20:19]));
      if (e[0]) chk($sformatf("R1 vec %0d empty", v), W'(top_empty[e[18:17]]), W'(1));
      else chk($sformatf("R1-vector %0d top", v), topof(int'(e[18:17])), e[16:1]);
    end

    // R8: underflow on empty pop, sticky, contents unchanged
    run1(2, 4'd2, '0, 0);
    chk("R8 pop empty err", W'(err_uflow[2]), W'(1));
    chk("R8 still empty", W'(top_empty[2]), W'(1));
    run1(2, 4'd1, 16'h0009, 0);
    chk("R8 sticky", W'(err_uflow[2]), W'(1));
    run1(3, 4'd1, 16'h0004, 0);
    run1(3, 4'd3, '0, 0);
    chk("R8 binary err", W'(err_uflow[3]), W'(1));
    chk("R8 top kept", topof(3), 16'h0004);
    chk("R8 other lanes clean", W'(err_uflow[1:0]), '0);

    // R9: all stacks accept on the same edge
    @(negedge clk);
    for (int l = 0; l < N; l++) drive(l, 4'd1, 16'hA000 + W'(l), 0);
    #1;
    chk("R9 all ready", W'(cmd_ready), W'(4'hF));
    @(negedge clk);
    cmd_valid = '0;
    for (int l = 0; l < N; l++) chk("R9 parallel top", topof(l), 16'hA000 + W'(l));

    // R10/R11: simultaneous spill on stacks 1 and 3
    run1(1, 4'd1, 16'hB001, 0);
    run1(1, 4'd1, 16'hB002, 0);
    run1(1, 4'd1, 16'hB003, 0);
    run1(3, 4'd1, 16'hC001, 0);
    run1(3, 4'd1, 16'hC002, 0);
    nlog = 0;
    @(negedge clk);
    drive(1, 4'd1, 16'hB004, 0);
    drive(3, 4'd1, 16'hC003, 0);
    @(negedge clk);
    cmd_valid = '0;
    #1;
    chk("R11 stall high", W'(stall[3]), W'(1));
    chk("R11 ready low", W'(cmd_ready[3]), W'(0));
    quiet();
    chk("R10 first served", W'(alog[0]), 16'h0010);
    chk("R10 second served", W'(alog[1]), 16'h0030);
    chk("R4 spilled value", mem[16], 16'hA001);
    chk("R4 top after spill", topof(3), 16'hC003);

    // R6: two transfers to stack 1 plus its own push in one cycle
    @(negedge clk);
    drive(0, 4'd10, '0, 1);
    drive(2, 4'd10, '0, 1);
    drive(1, 4'd1, 16'hBEEF, 0);
    #1;
    chk("R6 lowest source ready", W'(cmd_ready[0]), W'(1));
    chk("R6 other source waits", W'(cmd_ready[2]), W'(0));
    chk("R6 destination blocked", W'(cmd_ready[1]), W'(0));
    @(negedge clk);
    cmd_valid = '0;
    quiet();
    chk("R6 value moved", topof(1), 16'hA000);
    chk("R6 source empty", W'(top_empty[0]), W'(1));
    chk("R6 loser untouched", topof(2), 16'hA002);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule